// File: doc/BRIEF.md
# Edge-Selected Capture and Count Input Conditioner

This block sits in front of a general-purpose timer and turns slow external pulse inputs into events the timer can use. Every input first passes through a two-flop synchronizer and a one-flop history stage. Edges are then found by comparing each synchronized sample with the one before it. Each clock yields rising, falling or no change.

The same edge flags serve two purposes. In counter mode the block emits a one-clock count strobe for each edge of the chosen kind on the chosen input. The timer counter advances on that strobe in place of its prescaled tick. In timer mode the strobe is held high every clock, so the prescaler sees every system clock. In timer mode, edges on the capture input copy the timer counter value, which arrives as an input, into a read-only capture register. A capture can also raise a one-clock interrupt pulse, which the timer wires into its interrupt status register.

An input is only guaranteed to be tracked if it holds each level for at least one full clock. Its rate must therefore not exceed half the clock rate.

Top module: `cap_count_cond`

## Requirements
- R1: An edge on an input driven between two clocks affects `count_tick`, `cap_value` and `cap_irq` after the third rising clock edge that follows, and not earlier (two synchronizer flops plus one output register).
- R2: With `mode_sel` = 0 (timer mode), `count_tick` is high in every cycle that follows a clock edge at which `mode_sel` was 0.
- R3: With `mode_sel` = 1 only rising edges, with 2 only falling edges, and with 3 both edges of the selected input each produce exactly one single-cycle `count_tick` pulse.
- R4: In counter mode, `in_sel` = 0 selects `cap_in[0]` and `in_sel` = 1 selects `cap_in[1]`; `in_sel` = 2 or 3 produces no `count_tick` pulse whatever the inputs do.
- R5: Changing `in_sel` between inputs that sit at different steady levels produces no `count_tick` pulse.
- R6: In timer mode an edge on `cap_in[0]` loads `tc_value` into `cap_value` when it is a rising edge and `cap_ctrl[0]` is 1, or a falling edge and `cap_ctrl[1]` is 1. With both bits set, both edges load. In all other cycles `cap_value` holds.
- R7: `cap_irq` pulses for exactly one cycle, in the cycle `cap_value` is loaded, only when `cap_ctrl[2]` is 1. A load with `cap_ctrl[2]` = 0 still updates `cap_value`.
- R8: When `mode_sel` is not 0, edges on `cap_in[0]` neither change `cap_value` nor raise `cap_irq`, whatever `cap_ctrl` holds.
- R9: While `rst_n` is low, `count_tick`, `cap_irq` and `cap_value` are all 0.
- R10: An input that toggles on every clock (half the clock rate) with `mode_sel` = 3 yields one `count_tick` pulse per toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | NUM_IN | External asynchronous event inputs; index 0 also feeds capture |
| mode_sel | input | 2 | 0 timer mode, 1 count rising, 2 count falling, 3 count both edges |
| in_sel | input | 2 | Input picked for counting; codes at or above NUM_IN are reserved |
| cap_ctrl | input | 3 | Bit 0 capture on rise, bit 1 capture on fall, bit 2 interrupt on capture |
| tc_value | input | CNT_W | Current timer counter value |
| count_tick | output | 1 | Count/prescaler enable strobe |
| cap_value | output | CNT_W | Capture register contents |
| cap_irq | output | 1 | One-cycle capture interrupt pulse |

## Verification
The bench builds the block with its defaults: a 16-bit counter value, two event inputs and two synchronizer stages. With two inputs, the select codes 2 and 3 are reserved, so the bench can show that reserved selects stay silent and that switching between real inputs adds no pulses. With two synchronizer stages, the latency is fixed at three clocks, so the bench samples the exact cycle of each strobe, capture and interrupt, as well as the cycles on either side. The bench also toggles an input on every clock, to show that edges at half the clock rate are all counted.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [1:0] {
    CM_TIMER = 2'd0,
    CM_RISE  = 2'd1,
    CM_FALL  = 2'd2,
    CM_BOTH  = 2'd3
  } cnt_mode_e;

  localparam int CAP_CTRL_W = 3;
  localparam int CC_RISE_BIT = 0;
  localparam int CC_FALL_BIT = 1;
  localparam int CC_IRQ_BIT  = 2;

endpackage

// File: rtl/cc_sync_edge.sv
module cc_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;
  logic                   cur;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], din};
    prev_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign cur  = sync_q[SYNC_STAGES-1];
  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;

endmodule

// File: rtl/cc_count_sel.sv
module cc_count_sel
  import cc_pkg::*;
#(
  parameter int NUM_IN = 2,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [SEL_W-1:0]  in_sel,
  input  logic [NUM_IN-1:0] rise_v,
  input  logic [NUM_IN-1:0] fall_v,
  output logic              tick
);

  logic      sel_rise;
  logic      sel_fall;
  logic      tick_d;
  logic      tick_q;
  cnt_mode_e mode_e;

  assign mode_e = cnt_mode_e'(mode);

  always_comb begin
    sel_rise = 1'b0;
    sel_fall = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (int'(in_sel) == i) begin
        sel_rise = rise_v[i];
        sel_fall = fall_v[i];
      end
    end
  end

  always_comb begin
    unique case (mode_e)
      CM_TIMER: tick_d = 1'b1;
      CM_RISE:  tick_d = sel_rise;
      CM_FALL:  tick_d = sel_fall;
      CM_BOTH:  tick_d = sel_rise | sel_fall;
      default:  tick_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_d;
  end

  assign tick = tick_q;

  AST_TIMER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |=> tick_q); // R2

  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode != 2'd0) && (int'(in_sel) >= NUM_IN)) |=> !tick_q); // R4

endmodule

// File: rtl/cc_capture.sv
module cc_capture
  import cc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  timer_mode,
  input  logic                  rise,
  input  logic                  fall,
  input  logic [CAP_CTRL_W-1:0] ctrl,
  input  logic [CNT_W-1:0]      tc_value,
  output logic [CNT_W-1:0]      cap_value,
  output logic                  cap_irq
);

  logic             load;
  logic [CNT_W-1:0] cap_d;
  logic [CNT_W-1:0] cap_q;
  logic             irq_d;
  logic             irq_q;

  always_comb begin
    load  = timer_mode &
            ((ctrl[CC_RISE_BIT] & rise) | (ctrl[CC_FALL_BIT] & fall));
    cap_d = load ? tc_value : cap_q;
    irq_d = load & ctrl[CC_IRQ_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cap_q <= cap_d;
      irq_q <= irq_d;
    end
  end

  assign cap_value = cap_q;
  assign cap_irq   = irq_q;

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cap_q)); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[CC_IRQ_BIT] |=> !irq_q); // R7

  AST_NO_CAP_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
    !timer_mode |=> (!irq_q && $stable(cap_q))); // R8

endmodule

// File: rtl/cap_count_cond.sv
module cap_count_cond
  import cc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_IN      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_IN-1:0]     cap_in,
  input  logic [1:0]            mode_sel,
  input  logic [1:0]            in_sel,
  input  logic [CAP_CTRL_W-1:0] cap_ctrl,
  input  logic [CNT_W-1:0]      tc_value,
  output logic                  count_tick,
  output logic [CNT_W-1:0]      cap_value,
  output logic                  cap_irq
);

  localparam int SEL_W   = 2;
  localparam int CAP_IDX = 0;

  logic [NUM_IN-1:0] rise_v;
  logic [NUM_IN-1:0] fall_v;
  logic              timer_mode;

  assign timer_mode = (mode_sel == CM_TIMER);

  for (genvar g = 0; g < NUM_IN; g++) begin : g_in
    cc_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (cap_in[g]),
      .rise (rise_v[g]),
      .fall (fall_v[g])
    );
  end

  cc_count_sel #(.NUM_IN(NUM_IN), .SEL_W(SEL_W)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode_sel),
    .in_sel(in_sel),
    .rise_v(rise_v),
    .fall_v(fall_v),
    .tick  (count_tick)
  );

  cc_capture #(.CNT_W(CNT_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .timer_mode(timer_mode),
    .rise      (rise_v[CAP_IDX]),
    .fall      (fall_v[CAP_IDX]),
    .ctrl      (cap_ctrl),
    .tc_value  (tc_value),
    .cap_value (cap_value),
    .cap_irq   (cap_irq)
  );

endmodule

// File: tb/cap_count_cond_test.sv
module cap_count_cond_test;

  localparam int CNT_W       = 16;
  localparam int NUM_IN      = 2;
  localparam int SYNC_STAGES = 2;
  localparam int LAT         = SYNC_STAGES + 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NUM_IN-1:0] cap_in;
  logic [1:0]        mode_sel;
  logic [1:0]        in_sel;
  logic [2:0]        cap_ctrl;
  logic [CNT_W-1:0]  tc_value;
  logic              count_tick;
  logic [CNT_W-1:0]  cap_value;
  logic              cap_irq;

  int checks   = 0;
  int failures = 0;
  logic [CNT_W-1:0] exp_cap;

  always #4 clk = ~clk;

  cap_count_cond #(.CNT_W(CNT_W), .NUM_IN(NUM_IN), .SYNC_STAGES(SYNC_STAGES)) uut (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .mode_sel(mode_sel),
    .in_sel(in_sel), .cap_ctrl(cap_ctrl), .tc_value(tc_value),
    .count_tick(count_tick), .cap_value(cap_value), .cap_irq(cap_irq)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (LAT + 2) @(negedge clk);
  endtask

  task automatic count_window(int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      c += int'(count_tick);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cap_in = '0; mode_sel = 2'd0; in_sel = 2'd0;
    cap_ctrl = 3'b111; tc_value = 16'h7777;
    repeat (3) @(negedge clk);
    cap_in = 2'b11;
    repeat (4) @(negedge clk);
    check_eq("R9", "tick in reset", int'(count_tick), 0);
    check_eq("R9", "cap_value in reset", int'(cap_value), 0);
    check_eq("R9", "irq in reset", int'(cap_irq), 0);
    cap_in = '0;
    rst_n = 1'b1;
    exp_cap = '0;
    settle();
  endtask

  task automatic t_timer_mode();
    mode_sel = 2'd0; cap_ctrl = 3'b000;
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check_eq("R2", "timer mode tick", int'(count_tick), 1);
    end
  endtask

  task automatic t_latency();
    mode_sel = 2'd1; in_sel = 2'd0; cap_in = '0;
    settle();
    cap_in[0] = 1'b1;
    for (int k = 1; k <= LAT + 1; k++) begin
      @(negedge clk);
      check_eq("R1", $sformatf("tick at cycle %0d", k), int'(count_tick),
               (k == LAT) ? 1 : 0);
    end
    cap_in = '0;
    settle();
  endtask

  task automatic t_edges(logic [1:0] mode, int sel);
    int c;
    mode_sel = mode; in_sel = sel[1:0]; cap_in = '0; cap_ctrl = 3'b000;
    settle();
    cap_in[sel] = 1'b1;
    count_window(LAT + 3, c);
    check_eq("R3", $sformatf("rise count mode %0d in %0d", mode, sel), c, int'(mode[0]));
    cap_in[sel] = 1'b0;
    count_window(LAT + 3, c);
    check_eq("R3", $sformatf("fall count mode %0d in %0d", mode, sel), c, int'(mode[1]));
    cap_in[1 - sel] = 1'b1;
    count_window(LAT + 3, c);
    check_eq("R4", $sformatf("other input ignored in %0d", sel), c, 0);
    cap_in = '0;
    settle();
  endtask

  task automatic t_reserved_sel();
    int c;
    for (int s = 2; s < 4; s++) begin
      mode_sel = 2'd3; in_sel = s[1:0]; cap_in = '0;
      settle();
      cap_in = 2'b11;
      count_window(LAT + 2, c);
      cap_in = 2'b01;
      count_window(LAT + 2, c);
      check_eq("R4", $sformatf("reserved select %0d", s), c, 0);
      cap_in = '0;
      count_window(LAT + 2, c);
      check_eq("R4", $sformatf("reserved select %0d after fall", s), c, 0);
    end
  endtask

  task automatic t_sel_switch();
    int c;
    mode_sel = 2'd3; in_sel = 2'd0; cap_in = 2'b01;
    settle();
    in_sel = 2'd1;
    count_window(LAT + 3, c);
    check_eq("R5", "switch 0 to 1", c, 0);
    in_sel = 2'd0;
    count_window(LAT + 3, c);
    check_eq("R5", "switch 1 to 0", c, 0);
    cap_in = '0;
    settle();
  endtask

  task automatic t_capture_edge(logic [2:0] ctrl, logic lvl, logic [CNT_W-1:0] tc,
                                bit expect_load, string tag);
    cap_ctrl = ctrl; tc_value = tc;
    cap_in[0] = lvl;
    for (int k = 1; k <= LAT + 1; k++) begin
      @(negedge clk);
      if (k == LAT && expect_load) exp_cap = tc;
      check_eq("R6", $sformatf("%s cap at cycle %0d", tag, k), int'(cap_value), int'(exp_cap));
      check_eq("R7", $sformatf("%s irq at cycle %0d", tag, k), int'(cap_irq),
               (k == LAT && expect_load && ctrl[2]) ? 1 : 0);
    end
    settle();
  endtask

  task automatic t_capture();
    mode_sel = 2'd0; in_sel = 2'd0; cap_in = '0; cap_ctrl = 3'b000;
    settle();
    t_capture_edge(3'b101, 1'b1, 16'h1234, 1'b1, "rise+irq");
    t_capture_edge(3'b101, 1'b0, 16'h4321, 1'b0, "fall ignored");
    t_capture_edge(3'b010, 1'b1, 16'h0F0F, 1'b0, "rise ignored");
    t_capture_edge(3'b010, 1'b0, 16'hBEEF, 1'b1, "fall no irq");
    t_capture_edge(3'b111, 1'b1, 16'hFFFF, 1'b1, "both rise");
    t_capture_edge(3'b111, 1'b0, 16'h0001, 1'b1, "both fall");
  endtask

  task automatic t_capture_counting();
    int irqs;
    mode_sel = 2'd1; cap_ctrl = 3'b111; tc_value = 16'h5555; cap_in = '0;
    settle();
    irqs = 0;
    cap_in[0] = 1'b1;
    repeat (LAT + 3) begin
      @(negedge clk);
      irqs += int'(cap_irq);
    end
    cap_in[0] = 1'b0;
    repeat (LAT + 3) begin
      @(negedge clk);
      irqs += int'(cap_irq);
    end
    check_eq("R8", "cap_value in counter mode", int'(cap_value), int'(exp_cap));
    check_eq("R8", "irq in counter mode", irqs, 0);
  endtask

  task automatic t_fast();
    int c;
    mode_sel = 2'd3; in_sel = 2'd1; cap_in = '0; cap_ctrl = 3'b000;
    settle();
    fork
      begin
        for (int i = 0; i < 10; i++) begin
          cap_in[1] = ~cap_in[1];
          @(negedge clk);
        end
      end
      count_window(10 + LAT + 2, c);
    join
    check_eq("R10", "ticks at half clock rate", c, 10);
    cap_in = '0;
    settle();
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_timer_mode();
    t_latency();
    for (int m = 1; m < 4; m++) begin
      for (int s = 0; s < NUM_IN; s++) t_edges(m[1:0], s);
    end
    t_reserved_sel();
    t_sel_switch();
    t_capture();
    t_capture_counting();
    t_fast();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule